// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block sits between a host bus and the small embedded CPU of a PC-style keyboard controller. The host writes bytes into an input data register and reads bytes from an output data register or a shared status byte. The controller CPU drains the input register, fills the output register and owns part of the status byte. Handshake flags in the status byte tell each side when a byte is waiting. An interrupt line tells the controller CPU that the host has left a byte.

Every host write goes into the input register, whatever the address. The address bit of that write is recorded in the status byte as a command/data marker, so the controller firmware can tell commands from data. The controller can also set free-use status bits that the host can read but never change. The reset input is qualified: the registers clear only after it has been held for a minimum number of clock cycles, so a short glitch does nothing.

Top module: `kbd_host_mailbox`

## Requirements
- R1: Once `rst_req` has been high for at least RST_CYCLES (default 24) consecutive clock edges, the status byte, both data registers, the interrupt enable and `host_rdata` are cleared to zero.
- R2: A `rst_req` pulse shorter than RST_CYCLES clock edges leaves every register unchanged.
- R3: A host write (`host_wr`) at either address loads `host_wdata` into the input data register (`ctl_in_data`) and sets IBF, which is status bit 1.
- R4: On every host write, status bit 3 (command/data) takes the value of `host_addr`: 1 for a command, 0 for data.
- R5: A controller read of the input register (`ctl_rd_in`) clears IBF. If a host write happens in the same cycle, the write wins: IBF stays set and the new byte is kept.
- R6: `ctl_irq` is high exactly when IBF and the interrupt enable are both set. The enable is loaded from `ctl_ien_val` on `ctl_wr_ien` and resets to 0.
- R7: A controller write of the output register sets OBF, which is status bit 0. A host read at address 0 returns the output byte and clears OBF. If the controller writes in the same cycle as that host read, OBF stays set.
- R8: A host read at address 1 returns the status byte as it was before the read, and it does not clear OBF.
- R9: A controller status write changes only the user bits (mask 0xF4, which is bits 2 and 4 to 7). OBF, IBF and command/data are left as they are. Host activity never changes the user bits.
- R10: `host_rdata` is registered. It is valid in the cycle after `host_rd` and holds its value until the next host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all registers |
| rst_req | input | 1 | Active-high reset request, qualified by duration |
| host_addr | input | 1 | Host address: 0 selects data, 1 selects status |
| host_wr | input | 1 | One-cycle host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | One-cycle host read strobe |
| host_rdata | output | 8 | Registered host read data |
| ctl_rd_in | input | 1 | Controller read strobe for the input register |
| ctl_in_data | output | 8 | Input data register contents |
| ctl_wr_out | input | 1 | Controller write strobe for the output register |
| ctl_wdata | input | 8 | Controller output data |
| ctl_wr_stat | input | 1 | Controller write strobe for the user status bits |
| ctl_stat_data | input | 8 | Controller status write data |
| ctl_wr_ien | input | 1 | Controller write strobe for the interrupt enable |
| ctl_ien_val | input | 1 | New interrupt enable value |
| ctl_status | output | 8 | Current status byte |
| ctl_irq | output | 1 | Input-buffer-full interrupt to the controller |

## Verification
The hardest cases to reach from the ports are the collisions, where both sides act on the same flag in the same cycle, and the reset pulse that stops one cycle short of the qualifying length. The vector table places a host write and a controller drain in the same row, and a controller output write and a host data read in the same row. After each collision the bench checks both the flags and the data. Directed steps then hold `rst_req` for exactly 23 cycles on a design with non-zero state and check that nothing changed, then hold it for exactly 24 cycles and check that everything cleared.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 8;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;
  localparam logic [7:0] USER_MASK = 8'hF4;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/mbx_rst_qual.sv
module mbx_rst_qual #(
  parameter int RST_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_req,
  output logic rst_int
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q = '0;
  logic             rst_q = 1'b0;
  logic             live  = 1'b0;

  always_ff @(posedge clk) begin
    live <= 1'b1;
    if (!rst_req) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      rst_q <= (cnt_q >= CNT_FIRE);
    end
  end

  assign rst_int = rst_q;

  // R2
  rst_drop_chk: assert property (@(posedge clk) disable iff (!live)
    $fell(rst_req) |=> !rst_int);
endmodule

// File: rtl/mbx_in_chan.sv
module mbx_in_chan
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  host_wr,
  input  logic  host_addr,
  input  byte_t host_wdata,
  input  logic  ctl_rd,
  input  logic  ien_wr,
  input  logic  ien_val,
  output byte_t in_data,
  output logic  ibf,
  output logic  cd,
  output logic  irq
);
  byte_t data_q;
  logic  ibf_q, cd_q, ien_q, irq_q;
  logic  ibf_d, ien_d;

  always_comb begin
    ibf_d = ibf_q;
    if (host_wr)     ibf_d = 1'b1;
    else if (ctl_rd) ibf_d = 1'b0;
    ien_d = ien_wr ? ien_val : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ibf_q  <= 1'b0;
      cd_q   <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (host_wr) begin
        data_q <= host_wdata;
        cd_q   <= host_addr;
      end
      ibf_q <= ibf_d;
      ien_q <= ien_d;
      irq_q <= ibf_d & ien_d;
    end
  end

  assign in_data = data_q;
  assign ibf     = ibf_q;
  assign cd      = cd_q;
  assign irq     = irq_q;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R3
  ibf_set_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    host_wr |=> ibf);
  // R4
  cd_track_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    host_wr |=> cd == $past(host_addr));
  // R5
  ibf_clr_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    (ctl_rd && !host_wr) |=> !ibf);
  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    irq == (ibf && ien_q));
endmodule

// File: rtl/mbx_out_chan.sv
module mbx_out_chan
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ctl_wr,
  input  byte_t ctl_wdata,
  input  logic  host_take,
  output byte_t out_data,
  output logic  obf
);
  byte_t data_q;
  logic  obf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      obf_q  <= 1'b0;
    end else begin
      if (ctl_wr) begin
        data_q <= ctl_wdata;
        obf_q  <= 1'b1;
      end else if (host_take) begin
        obf_q  <= 1'b0;
      end
    end
  end

  assign out_data = data_q;
  assign obf      = obf_q;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R7
  obf_set_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    ctl_wr |=> obf);
  // R7
  obf_clr_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    (host_take && !ctl_wr) |=> !obf);
endmodule

// File: rtl/kbd_host_mailbox.sv
module kbd_host_mailbox
  import mbx_pkg::*;
#(
  parameter int RST_CYCLES = 24
) (
  input  logic       clk,
  input  logic       rst_req,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  input  logic       ctl_rd_in,
  output logic [7:0] ctl_in_data,
  input  logic       ctl_wr_out,
  input  logic [7:0] ctl_wdata,
  input  logic       ctl_wr_stat,
  input  logic [7:0] ctl_stat_data,
  input  logic       ctl_wr_ien,
  input  logic       ctl_ien_val,
  output logic [7:0] ctl_status,
  output logic       ctl_irq
);
  logic  rst;
  logic  ibf, cd, obf;
  byte_t out_data;
  byte_t user_q;
  byte_t rdata_q;
  logic [7:0] status;

  mbx_rst_qual #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_req(rst_req), .rst_int(rst)
  );

  mbx_in_chan u_in (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .ctl_rd(ctl_rd_in), .ien_wr(ctl_wr_ien),
    .ien_val(ctl_ien_val), .in_data(ctl_in_data), .ibf(ibf), .cd(cd),
    .irq(ctl_irq)
  );

  mbx_out_chan u_out (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr_out), .ctl_wdata(ctl_wdata),
    .host_take(host_rd && !host_addr), .out_data(out_data), .obf(obf)
  );

  always_comb begin
    status          = user_q & USER_MASK;
    status[OBF_BIT] = obf;
    status[IBF_BIT] = ibf;
    status[CD_BIT]  = cd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      user_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (ctl_wr_stat) user_q <= ctl_stat_data & USER_MASK;
      if (host_rd)     rdata_q <= host_addr ? status : out_data;
    end
  end

  assign ctl_status = status;
  assign host_rdata = rdata_q;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R9
  user_keep_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    !ctl_wr_stat |=> $stable(ctl_status & USER_MASK));
  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    (ctl_wr_stat && !host_wr && !ctl_rd_in && !ctl_wr_out && !host_rd)
      |=> $stable(ctl_status & ~USER_MASK));
  // R8
  stat_read_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    (host_rd && host_addr) |=> host_rdata == $past(ctl_status));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!armed || rst)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/kbd_host_mailbox_tb.sv
module kbd_host_mailbox_tb;
  logic       clk = 1'b0;
  logic       rst_req = 1'b0;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       ctl_rd_in = 1'b0, ctl_wr_out = 1'b0, ctl_wr_stat = 1'b0;
  logic       ctl_wr_ien = 1'b0, ctl_ien_val = 1'b0;
  logic [7:0] ctl_wdata = '0, ctl_stat_data = '0;
  logic [7:0] ctl_in_data, ctl_status;
  logic       ctl_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kbd_host_mailbox u_dut (
    .clk(clk), .rst_req(rst_req), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .ctl_rd_in(ctl_rd_in), .ctl_in_data(ctl_in_data), .ctl_wr_out(ctl_wr_out),
    .ctl_wdata(ctl_wdata), .ctl_wr_stat(ctl_wr_stat),
    .ctl_stat_data(ctl_stat_data), .ctl_wr_ien(ctl_wr_ien),
    .ctl_ien_val(ctl_ien_val), .ctl_status(ctl_status), .ctl_irq(ctl_irq)
  );

  typedef struct packed {
    logic       hwr;
    logic       ha;
    logic [7:0] hwd;
    logic       hrd;
    logic       crd;
    logic       cwo;
    logic [7:0] cwd;
    logic       cws;
    logic [7:0] csd;
    logic       iew;
    logic       iev;
    logic [7:0] e_stat;
    logic [7:0] e_rd;
    logic [7:0] e_in;
    logic       e_irq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,8'h5A, 1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h02,8'h00,8'h5A,1'b0}, // R3 R4
    '{1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b1, 8'h02,8'h00,8'h5A,1'b1}, // R6
    '{1'b1,1'b1,8'hC3, 1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h0A,8'h00,8'hC3,1'b1}, // R4
    '{1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h08,8'h00,8'hC3,1'b0}, // R5
    '{1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,8'h96, 1'b0,8'h00, 1'b0,1'b0, 8'h09,8'h00,8'hC3,1'b0}, // R7
    '{1'b0,1'b1,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h09,8'h09,8'hC3,1'b0}, // R8
    '{1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h08,8'h96,8'hC3,1'b0}, // R7
    '{1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b1,8'hFF, 1'b0,1'b0, 8'hFC,8'h96,8'hC3,1'b0}, // R9
    '{1'b1,1'b0,8'h11, 1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'hF6,8'h96,8'h11,1'b1}, // R9 R10
    '{1'b1,1'b0,8'h22, 1'b0,1'b1,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'hF6,8'h96,8'h22,1'b1}, // R5
    '{1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 1'b1,8'h00, 1'b0,1'b0, 8'h00,8'h96,8'h22,1'b0}, // R9
    '{1'b0,1'b0,8'h00, 1'b1,1'b0,1'b1,8'h3C, 1'b0,8'h00, 1'b0,1'b0, 8'h01,8'h96,8'h22,1'b0}, // R7
    '{1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 8'h00,8'h3C,8'h22,1'b0}, // R7
    '{1'b1,1'b1,8'h77, 1'b0,1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b1,1'b0, 8'h0A,8'h3C,8'h77,1'b0}  // R6
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = '0;
    ctl_rd_in = 0; ctl_wr_out = 0; ctl_wr_stat = 0; ctl_wr_ien = 0;
    ctl_ien_val = 0; ctl_wdata = '0; ctl_stat_data = '0;
  endtask

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic hold_reset(int n);
    rst_req = 1'b1;
    repeat (n) step();
    rst_req = 1'b0;
    repeat (2) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    idle();
    repeat (2) step();
    hold_reset(30);
    // R1 reset state
    check("R1", "status", ctl_status, 8'h00);
    check("R1", "rdata", host_rdata, 8'h00);
    check("R1", "in_data", ctl_in_data, 8'h00);
    check("R1", "irq", {7'd0, ctl_irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      host_wr = TBL[i].hwr; host_addr = TBL[i].ha; host_wdata = TBL[i].hwd;
      host_rd = TBL[i].hrd; ctl_rd_in = TBL[i].crd; ctl_wr_out = TBL[i].cwo;
      ctl_wdata = TBL[i].cwd; ctl_wr_stat = TBL[i].cws;
      ctl_stat_data = TBL[i].csd; ctl_wr_ien = TBL[i].iew;
      ctl_ien_val = TBL[i].iev;
      step();
      idle();
      check($sformatf("R3-vec%0d", i), "status", ctl_status, TBL[i].e_stat);
      check($sformatf("R10-vec%0d", i), "rdata", host_rdata, TBL[i].e_rd);
      check($sformatf("R3-vec%0d", i), "in_data", ctl_in_data, TBL[i].e_in);
      check($sformatf("R6-vec%0d", i), "irq", {7'd0, ctl_irq}, {7'd0, TBL[i].e_irq});
    end

    // R2: a 23-cycle pulse must change nothing
    hold_reset(23);
    check("R2", "status", ctl_status, 8'h0A);
    check("R2", "in_data", ctl_in_data, 8'h77);
    check("R2", "rdata", host_rdata, 8'h3C);

    // R1: exactly 24 cycles clears everything
    hold_reset(24);
    check("R1", "status", ctl_status, 8'h00);
    check("R1", "in_data", ctl_in_data, 8'h00);
    check("R1", "rdata", host_rdata, 8'h00);

    // R6: enable cleared by reset, so a host write raises no interrupt
    host_wr = 1; host_addr = 0; host_wdata = 8'hA5;
    step();
    idle();
    check("R6", "irq", {7'd0, ctl_irq}, 8'h00);
    check("R3", "status", ctl_status, 8'h02);

    finish_run();
  end
endmodule